// File: doc/BRIEF.md
# Reconfigurable Array Processing-Element Datapath

This block is the arithmetic heart of one tile in a coarse-grained reconfigurable array. It receives three data operands from the routing fabric. A static configuration picks one of fourteen operations, a signed or unsigned interpretation, and one condition code. The block returns a data result and a single condition bit that feeds the one-bit track network. The configuration is held steady while the array runs, so the datapath is purely combinational from operand to output.

Each operand passes through its own source stage. That stage supplies the live wire value, a configured constant, or the output of a per-operand pipeline register. This lets the place-and-route flow fold constants and registers into the tile without spending routing tracks on them. The zero, negative, carry and overflow flags are derived from the operation result. The condition selector reduces them to one bit using the familiar conditional-execution predicates.

Top module: `pe_tile`

## Requirements
- R1: After reset every operand pipeline register holds zero, so an operand sourced from its register reads 0 until the first enabled clock edge.
- R2: The 2-bit source code for operand k is at `cfg_src[2k+1:2k]` (A=0, B=1, C=2): 0 selects the wire, 1 the constant at `cfg_const[16k+15:16k]`, 2 the pipeline register, and 3 also selects the wire.
- R3: On each rising clock edge with `en` high, every pipeline register captures its wire input. With `en` low, the registers hold their value.
- R4: Opcode 0 (add) and opcode 1 (sub, first minus second) return the result modulo 2^16. For add, C is the carry out. For sub, C is 1 exactly when A >= B, read as unsigned numbers.
- R5: Opcodes 3 (max) and 4 (min) return A when A >= B (max) or A <= B (min), and return B otherwise. The compare is signed when `cfg_signed` is 1. C is 1 when A is returned.
- R6: With `cfg_signed`=1, V is the two's-complement overflow of add or sub. With `cfg_signed`=0, V equals C for add and equals NOT C for sub. For opcode 2 (abs), V is 1 only for signed 0x8000. For all other opcodes, C and V are 0.
- R7: Opcode 2 (abs) returns the two's-complement magnitude of A when `cfg_signed`=1 and A is negative. Otherwise it returns A unchanged.
- R8: Opcode 5 (select) returns A when bit 0 of C is 1, and returns B otherwise.
- R9: Opcodes 6, 7 and 8 return bits [15:0], [23:8] and [31:16] of the 32-bit product A*B. The operands are sign-extended when `cfg_signed`=1.
- R10: Opcode 9 shifts A right and opcode 10 shifts A left, by B[3:0] places. The right shift is arithmetic when `cfg_signed`=1 and logical otherwise.
- R11: Opcodes 11, 12 and 13 give A|B, A&B and A^B. Opcodes 14 and 15 give a zero result.
- R12: Z is set when the result is zero and N is bit 15 of the result, for every opcode.
- R13: `cond_out` follows `cfg_cond` with this encoding. 0 gives Z, 1 gives !Z, 2 gives C, 3 gives !C, 4 gives N, 5 gives !N, 6 gives V, 7 gives !V, 8 gives C&!Z, 9 gives !C|Z, 10 gives N==V, 11 gives N!=V, 12 gives !Z&(N==V), 13 gives Z|(N!=V). Codes 14 and 15 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the operand pipeline registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Global load enable for the pipeline registers |
| cfg_op | input | 4 | Operation code |
| cfg_signed | input | 1 | 1 selects the signed interpretation |
| cfg_cond | input | 4 | Condition code routed to `cond_out` |
| cfg_src | input | 6 | Source code for each operand, 2 bits each |
| cfg_const | input | 48 | Constant for each operand, 16 bits each |
| in_a | input | 16 | Operand A wire |
| in_b | input | 16 | Operand B wire |
| in_c | input | 16 | Operand C wire (select input) |
| result | output | 16 | Data result |
| cond_out | output | 1 | Selected condition bit |

## Verification
The bench builds the tile with its default 16-bit data width. At that width, the four width-critical corner values 0, 0x7FFF, 0x8000 and 0xFFFF can be applied directly, together with every shift amount from 0 to 15. Sign-boundary overflow, the abs edge case at 0x8000, and all three product slices become reachable in both signed and unsigned modes. Every opcode and signedness is paired with every corner pair, and all fourteen condition codes are read at each point. A further scenario drives random operands, and the source and register scenarios exercise folding and the enable.

// File: rtl/pe_pkg.sv
package pe_pkg;

    localparam int OP_W  = 4;
    localparam int CC_W  = 4;
    localparam int SRC_W = 2;
    localparam int N_OPND = 3;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_ABS  = 4'd2,
        OP_MAX  = 4'd3,
        OP_MIN  = 4'd4,
        OP_SEL  = 4'd5,
        OP_MULL = 4'd6,
        OP_MULM = 4'd7,
        OP_MULH = 4'd8,
        OP_SHR  = 4'd9,
        OP_SHL  = 4'd10,
        OP_OR   = 4'd11,
        OP_AND  = 4'd12,
        OP_XOR  = 4'd13
    } pe_op_e;

    typedef enum logic [CC_W-1:0] {
        CC_EQ = 4'd0,
        CC_NE = 4'd1,
        CC_CS = 4'd2,
        CC_CC = 4'd3,
        CC_MI = 4'd4,
        CC_PL = 4'd5,
        CC_VS = 4'd6,
        CC_VC = 4'd7,
        CC_HI = 4'd8,
        CC_LS = 4'd9,
        CC_GE = 4'd10,
        CC_LT = 4'd11,
        CC_GT = 4'd12,
        CC_LE = 4'd13
    } pe_cc_e;

    typedef enum logic [SRC_W-1:0] {
        SRC_WIRE  = 2'd0,
        SRC_CONST = 2'd1,
        SRC_PIPE  = 2'd2,
        SRC_ALT   = 2'd3
    } pe_src_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
        logic v;
    } pe_flags_t;

endpackage

// File: rtl/pe_operand_src.sv
module pe_operand_src
    import pe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DW-1:0]    wire_in,
    input  logic [DW-1:0]    const_in,
    input  logic [SRC_W-1:0] src,
    output logic [DW-1:0]    opnd
);

    logic [DW-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else if (en) begin
            pipe_q <= wire_in;
        end
    end

    always_comb begin
        case (pe_src_e'(src))
            SRC_CONST: opnd = const_in;
            SRC_PIPE:  opnd = pipe_q;
            default:   opnd = wire_in;
        endcase
    end

    // R3
    pipe_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(en)) |-> (pipe_q == $past(wire_in)));

    // R3
    pipe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(en)) |-> $stable(pipe_q));

endmodule

// File: rtl/pe_alu_core.sv
module pe_alu_core
    import pe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic            sgn,
    input  logic [OP_W-1:0] op,
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic [DW-1:0]   c,
    output logic [DW-1:0]   res,
    output pe_flags_t       flags
);

    localparam int MSB = DW - 1;
    localparam int PW  = 2 * DW;
    localparam int MID = DW / 2;
    localparam int SHW = $clog2(DW);

    logic [DW:0]          sum_x;
    logic [DW:0]          dif_x;
    logic [PW-1:0]        a_ext;
    logic [PW-1:0]        b_ext;
    logic [PW-1:0]        prod;
    logic                 a_ge_b;
    logic                 a_le_b;
    logic                 v_add_s;
    logic                 v_sub_s;
    logic signed [DW-1:0] a_s;
    logic [DW-1:0]        sra_v;
    logic [DW-1:0]        srl_v;
    logic [DW-1:0]        sll_v;
    logic [DW-1:0]        neg_a;
    logic [SHW-1:0]       sh_amt;
    logic                 c_f;
    logic                 v_f;
    logic                 unused_c_hi;

    assign unused_c_hi = ^c[DW-1:1];

    assign sum_x = {1'b0, a} + {1'b0, b};
    assign dif_x = {1'b0, a} - {1'b0, b};

    assign v_add_s = (a[MSB] == b[MSB]) && (sum_x[MSB] != a[MSB]);
    assign v_sub_s = (a[MSB] != b[MSB]) && (dif_x[MSB] != a[MSB]);

    assign a_ext = sgn ? {{DW{a[MSB]}}, a} : {{DW{1'b0}}, a};
    assign b_ext = sgn ? {{DW{b[MSB]}}, b} : {{DW{1'b0}}, b};
    assign prod  = a_ext * b_ext;

    assign a_ge_b = sgn ? ($signed(a) >= $signed(b)) : (a >= b);
    assign a_le_b = sgn ? ($signed(a) <= $signed(b)) : (a <= b);

    assign a_s    = a;
    assign sh_amt = b[SHW-1:0];
    assign sra_v  = a_s >>> sh_amt;
    assign srl_v  = a >> sh_amt;
    assign sll_v  = a << sh_amt;
    assign neg_a  = '0 - a;

    always_comb begin
        res = '0;
        c_f = 1'b0;
        v_f = 1'b0;
        case (pe_op_e'(op))
            OP_ADD: begin
                res = sum_x[DW-1:0];
                c_f = sum_x[DW];
                v_f = sgn ? v_add_s : sum_x[DW];
            end
            OP_SUB: begin
                res = dif_x[DW-1:0];
                c_f = ~dif_x[DW];
                v_f = sgn ? v_sub_s : dif_x[DW];
            end
            OP_ABS: begin
                res = (sgn && a[MSB]) ? neg_a : a;
                v_f = sgn && a[MSB] && (a[MSB-1:0] == '0);
            end
            OP_MAX: begin
                res = a_ge_b ? a : b;
                c_f = a_ge_b;
            end
            OP_MIN: begin
                res = a_le_b ? a : b;
                c_f = a_le_b;
            end
            OP_SEL:  res = c[0] ? a : b;
            OP_MULL: res = prod[DW-1:0];
            OP_MULM: res = prod[MID+DW-1:MID];
            OP_MULH: res = prod[PW-1:DW];
            OP_SHR:  res = sgn ? sra_v : srl_v;
            OP_SHL:  res = sll_v;
            OP_OR:   res = a | b;
            OP_AND:  res = a & b;
            OP_XOR:  res = a ^ b;
            default: res = '0;
        endcase
    end

    always_comb begin
        flags.z = (res == '0);
        flags.n = res[MSB];
        flags.c = c_f;
        flags.v = v_f;
    end

endmodule

// File: rtl/pe_cond_sel.sv
module pe_cond_sel
    import pe_pkg::*;
(
    input  logic [CC_W-1:0] cc,
    input  pe_flags_t       flags,
    output logic            hit
);

    logic n_eq_v;

    assign n_eq_v = (flags.n == flags.v);

    always_comb begin
        case (pe_cc_e'(cc))
            CC_EQ:   hit = flags.z;
            CC_NE:   hit = ~flags.z;
            CC_CS:   hit = flags.c;
            CC_CC:   hit = ~flags.c;
            CC_MI:   hit = flags.n;
            CC_PL:   hit = ~flags.n;
            CC_VS:   hit = flags.v;
            CC_VC:   hit = ~flags.v;
            CC_HI:   hit = flags.c & ~flags.z;
            CC_LS:   hit = ~flags.c | flags.z;
            CC_GE:   hit = n_eq_v;
            CC_LT:   hit = ~n_eq_v;
            CC_GT:   hit = ~flags.z & n_eq_v;
            CC_LE:   hit = flags.z | ~n_eq_v;
            default: hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pe_tile.sv
module pe_tile
    import pe_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [OP_W-1:0]        cfg_op,
    input  logic                   cfg_signed,
    input  logic [CC_W-1:0]        cfg_cond,
    input  logic [N_OPND*SRC_W-1:0] cfg_src,
    input  logic [N_OPND*DW-1:0]   cfg_const,
    input  logic [DW-1:0]          in_a,
    input  logic [DW-1:0]          in_b,
    input  logic [DW-1:0]          in_c,
    output logic [DW-1:0]          result,
    output logic                   cond_out
);

    logic [N_OPND-1:0][DW-1:0] wire_v;
    logic [N_OPND-1:0][DW-1:0] opnd_v;
    pe_flags_t                 flags;

    assign wire_v = {in_c, in_b, in_a};

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
        pe_operand_src #(.DW(DW)) u_src (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .wire_in  (wire_v[gi]),
            .const_in (cfg_const[gi*DW +: DW]),
            .src      (cfg_src[gi*SRC_W +: SRC_W]),
            .opnd     (opnd_v[gi])
        );
    end

    pe_alu_core #(.DW(DW)) u_core (
        .sgn   (cfg_signed),
        .op    (cfg_op),
        .a     (opnd_v[0]),
        .b     (opnd_v[1]),
        .c     (opnd_v[2]),
        .res   (result),
        .flags (flags)
    );

    pe_cond_sel u_cond (
        .cc    (cfg_cond),
        .flags (flags),
        .hit   (cond_out)
    );

    // R13
    eq_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cond == CC_EQ) |-> (cond_out == (result == '0)));

    // R13
    mi_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_cond == CC_MI) |-> (cond_out == result[DW-1]));

    // R5
    max_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_op == OP_MAX && !cfg_signed) |-> (result >= opnd_v[0] && result >= opnd_v[1]));

    // R5
    min_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_op == OP_MIN && !cfg_signed) |-> (result <= opnd_v[0] && result <= opnd_v[1]));

    // R8
    sel_choice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_op == OP_SEL) |-> (result == opnd_v[0] || result == opnd_v[1]));

endmodule

// File: tb/test_pe_tile.sv
`timescale 1ns/1ps
module test_pe_tile;

    localparam int DW = 16;

    logic           clk;
    logic           rst_n;
    logic           en;
    logic [3:0]     cfg_op;
    logic           cfg_signed;
    logic [3:0]     cfg_cond;
    logic [5:0]     cfg_src;
    logic [47:0]    cfg_const;
    logic [DW-1:0]  in_a;
    logic [DW-1:0]  in_b;
    logic [DW-1:0]  in_c;
    logic [DW-1:0]  result;
    logic           cond_out;

    int n_checks = 0;
    int n_fails  = 0;

    logic [15:0] corner [6] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h0001, 16'h1235};

    pe_tile #(.DW(DW)) i_pe_tile (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (en),
        .cfg_op     (cfg_op),
        .cfg_signed (cfg_signed),
        .cfg_cond   (cfg_cond),
        .cfg_src    (cfg_src),
        .cfg_const  (cfg_const),
        .in_a       (in_a),
        .in_b       (in_b),
        .in_c       (in_c),
        .result     (result),
        .cond_out   (cond_out)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    initial begin
        #(8 * 150000);
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual running expected done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // returns {result, z, n, c, v}
    function automatic logic [19:0] ref_pe(input int op, input bit sgn,
                                           input logic [15:0] a, input logic [15:0] b,
                                           input logic [15:0] c);
        int sa, sb, full, amt;
        longint prod;
        logic [15:0] r;
        bit cf, vf;
        sa = int'($signed(a));
        sb = int'($signed(b));
        amt = int'(b[3:0]);
        r = '0; cf = 0; vf = 0; full = 0; prod = 0;
        case (op)
            0: begin
                full = int'(a) + int'(b);
                r = full[15:0];
                cf = full > 65535;
                vf = sgn ? ((sa + sb) > 32767 || (sa + sb) < -32768) : cf;
            end
            1: begin
                full = int'(a) - int'(b);
                r = full[15:0];
                cf = (a >= b);
                vf = sgn ? ((sa - sb) > 32767 || (sa - sb) < -32768) : !cf;
            end
            2: begin
                if (sgn && sa < 0) begin
                    full = -sa;
                    r = full[15:0];
                end else begin
                    r = a;
                end
                vf = sgn && (a == 16'h8000);
            end
            3: begin cf = sgn ? (sa >= sb) : (a >= b); r = cf ? a : b; end
            4: begin cf = sgn ? (sa <= sb) : (a <= b); r = cf ? a : b; end
            5: r = c[0] ? a : b;
            6, 7, 8: begin
                prod = sgn ? longint'(sa) * longint'(sb) : longint'(a) * longint'(b);
                if (op == 6) r = prod[15:0];
                else if (op == 7) r = prod[23:8];
                else r = prod[31:16];
            end
            9: begin
                full = sa >>> amt;
                r = sgn ? full[15:0] : (a >> amt);
            end
            10: r = a << amt;
            11: r = a | b;
            12: r = a & b;
            13: r = a ^ b;
            default: r = '0;
        endcase
        return {r, (r == 16'h0), r[15], cf, vf};
    endfunction

    function automatic bit ref_cond(input int cc, input logic [3:0] f);
        bit z, n, c, v;
        {z, n, c, v} = f;
        case (cc)
            0: return z;
            1: return !z;
            2: return c;
            3: return !c;
            4: return n;
            5: return !n;
            6: return v;
            7: return !v;
            8: return c && !z;
            9: return !c || z;
            10: return n == v;
            11: return n != v;
            12: return !z && (n == v);
            13: return z || (n != v);
            default: return 0;
        endcase
    endfunction

    function automatic string req_of_op(input int op);
        case (op)
            0, 1: return "R4";
            2: return "R7";
            3, 4: return "R5";
            5: return "R8";
            6, 7, 8: return "R9";
            9, 10: return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic string req_of_cc(input int cc);
        case (cc)
            2, 3: return "R4";
            6, 7: return "R6";
            0, 1, 4, 5: return "R12";
            default: return "R13";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s op=%0d sgn=%0d cc=%0d a=%h b=%h c=%h: actual %h expected %h",
                     req, cfg_op, cfg_signed, cfg_cond, in_a, in_b, in_c, act, exp);
        end
    endtask

    // full vector: result then every condition code
    task automatic apply_vec(input int op, input bit sgn,
                             input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
        logic [19:0] exp;
        exp = ref_pe(op, sgn, a, b, c);
        cfg_op = 4'(op); cfg_signed = sgn;
        in_a = a; in_b = b; in_c = c;
        cfg_cond = 4'd0;
        #1;
        check(req_of_op(op), result, exp[19:4]);
        for (int cc = 0; cc < 16; cc++) begin
            cfg_cond = 4'(cc);
            #1;
            check(req_of_cc(cc), {15'd0, cond_out}, {15'd0, ref_cond(cc, exp[3:0])});
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; en = 1'b0;
        cfg_src = {2'd2, 2'd2, 2'd2};
        cfg_const = '0;
        cfg_op = 4'd11; cfg_signed = 1'b0; cfg_cond = 4'd0;
        in_a = 16'h1234; in_b = 16'h00F0; in_c = 16'h0001;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: registers zero after reset, OR of them is zero
        check("R1", result, 16'h0000);
        cfg_op = 4'd0;
        #1;
        check("R1", result, 16'h0000);
    endtask

    task automatic t_sources;
        en = 1'b0;
        cfg_const = {16'h0001, 16'h0200, 16'h0030};
        cfg_op = 4'd0; cfg_signed = 1'b0; cfg_cond = 4'd0;
        in_a = 16'h1000; in_b = 16'h0004; in_c = 16'h0000;
        cfg_src = {2'd0, 2'd1, 2'd1};
        #1;
        // R2: both constants
        check("R2", result, 16'h0230);
        cfg_src = {2'd0, 2'd0, 2'd1};
        #1;
        check("R2", result, 16'h0034);
        cfg_src = {2'd0, 2'd3, 2'd3};
        #1;
        // R2: code 3 behaves as wire
        check("R2", result, 16'h1004);
        cfg_op = 4'd5;
        cfg_src = {2'd1, 2'd0, 2'd0};
        #1;
        // R2: select bit from constant C (bit0=1) picks A
        check("R2", result, 16'h1000);
    endtask

    task automatic t_pipe;
        cfg_op = 4'd0; cfg_signed = 1'b0;
        cfg_src = {2'd0, 2'd2, 2'd2};
        @(negedge clk);
        en = 1'b1; in_a = 16'h0005; in_b = 16'h0007;
        @(negedge clk);
        en = 1'b0; in_a = 16'h0100; in_b = 16'h0200;
        #1;
        // R3: registers captured 5 and 7
        check("R3", result, 16'h000C);
        @(negedge clk);
        #1;
        // R3: enable low holds
        check("R3", result, 16'h000C);
        cfg_src = {2'd0, 2'd0, 2'd2};
        #1;
        check("R3", result, 16'h0205);
        en = 1'b1;
        @(negedge clk);
        en = 1'b0;
        cfg_src = {2'd0, 2'd2, 2'd2};
        #1;
        check("R3", result, 16'h0300);
    endtask

    task automatic t_corners;
        en = 1'b0;
        cfg_src = '0;
        for (int op = 0; op < 16; op++) begin
            for (int s = 0; s < 2; s++) begin
                for (int i = 0; i < 6; i++) begin
                    for (int j = 0; j < 6; j++) begin
                        apply_vec(op, bit'(s), corner[i], corner[j], corner[(i + j) % 6]);
                    end
                end
            end
        end
    endtask

    task automatic t_shift_sweep;
        cfg_src = '0;
        for (int s = 0; s < 2; s++) begin
            for (int amt = 0; amt < 16; amt++) begin
                apply_vec(9, bit'(s), 16'h8F0F, 16'(amt), 16'h0);
                apply_vec(10, bit'(s), 16'h8F0F, 16'(amt), 16'h0);
            end
        end
    endtask

    task automatic t_random;
        cfg_src = '0;
        for (int k = 0; k < 400; k++) begin
            apply_vec(k % 16, bit'((k / 16) % 2), 16'($urandom), 16'($urandom), 16'($urandom));
        end
    endtask

    initial begin
        t_reset();
        t_sources();
        t_pipe();
        t_corners();
        t_shift_sweep();
        t_random();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule